// File: doc/BRIEF.md
# External Cascade Acknowledge Glue

This block sits between a processor bus and a set of external slave interrupt controllers. It does two jobs. First, it decodes the bus-status lines into one active-low acknowledge strobe. Second, it lets each external slave know whether the current acknowledge belongs to it.

A full acknowledge consists of two bus cycles with idle states between them. When the cascade-enable configuration input is set, the master controller's cascade code appears on three high address pins during the first cycle. The processor forces those pins high during the idle gap and during the second cycle. The block therefore captures the code on the first acknowledge cycle and holds it through the second one. It compares the held code with a fixed identity for each external slave and raises that slave's select. If the second cycle never arrives within a programmable number of clocks, the held state is dropped.

Every output is registered. It reflects the inputs sampled on the previous rising clock edge. The block carries no streaming data, so there is no valid/ready handshake: every pin is a plain level, and the block never back-pressures the bus.

Top module: `xcas_ack_glue`

## Requirements
- R1: After reset, and on any reset, xack_n is 1, slave_sel is all zero, ack_phase is 0 and cas_code is 0.
- R2: An acknowledge cycle is sampled when ads_n=0, mio_n=0, dc_n=0, wr_n=0 and refresh_n=1. xack_n is 0 in the cycle after such an edge and 1 after every other combination of these five lines, whatever cas_en is.
- R3: With cas_en=1 and ack_phase=0, an acknowledge cycle loads cas_code from addr_cas and sets ack_phase to 1.
- R4: With cas_en=1 and ack_phase=1, an acknowledge cycle leaves cas_code unchanged, even when addr_cas reads 3'b111, and clears ack_phase to 0.
- R5: With cas_en=0 the block captures nothing. After any edge with cas_en=0, ack_phase is 0, cas_code is 0 and slave_sel is all zero, even when an acknowledge cycle was sampled.
- R6: slave_sel[i] is 1 in the cycle after an acknowledge edge with cas_en=1 exactly when the effective code equals slot i's identity. The effective code is addr_cas in the first cycle and the held cas_code in the second. slave_sel[i] is 0 in every other cycle. Slot i's identity is bits [3i+2:3i] of SLAVE_IDS.
- R7: At most one bit of slave_sel is 1 at any time, given distinct slave identities.
- R8: When ack_phase=1, cas_en=1 and TIMEOUT consecutive edges pass with no acknowledge cycle, ack_phase returns to 0 and cas_code to 0 on the TIMEOUT-th such edge. After TIMEOUT-1 such edges both still hold.
- R9: Between the two acknowledge cycles, changes on addr_cas and bus cycles that are not acknowledges leave cas_code unchanged until the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cas_en | input | 1 | Configuration bit: the cascade code is driven on addr_cas |
| addr_cas | input | CODE_W | High address pins carrying the cascade code |
| ads_n | input | 1 | Address strobe, active low |
| mio_n | input | 1 | Memory/IO status (low = IO) |
| dc_n | input | 1 | Data/control status (low = control) |
| wr_n | input | 1 | Write/read status (low = read) |
| refresh_n | input | 1 | Refresh status, active low |
| xack_n | output | 1 | External acknowledge strobe, active low |
| ack_phase | output | 1 | 1 while waiting for the second acknowledge cycle |
| cas_code | output | CODE_W | Held cascade code |
| slave_sel | output | N_SLAVES | One select per external slave |

## Verification
The strobe decoder is driven with a table of status combinations. Each entry differs from the acknowledge pattern in a single line, so a decoder that ignores any one line, or inverts its sense, shows up.

Acknowledge pairs are then run with the address pins forced to all ones in the second cycle. One slave's identity is 7, so using the live pins in place of the held code selects the wrong slave. A code that matches no slave shows that no select appears spuriously.

Idle gaps are run with changing address values, stopping one edge short of the timeout and then reaching it, which separates the hold from the timeout boundary. Clearing the enable bit mid-sequence shows that the state is dropped and that no capture takes place while the bit is clear.

// File: rtl/xcas_pkg.sv
package xcas_pkg;
  typedef struct packed {
    logic ads_n;
    logic mio_n;
    logic dc_n;
    logic wr_n;
    logic refresh_n;
  } bus_stat_t;

  function automatic logic is_int_ack(input bus_stat_t s);
    return !s.ads_n && !s.mio_n && !s.dc_n && !s.wr_n && s.refresh_n;
  endfunction
endpackage

// File: rtl/xcas_status_dec.sv
module xcas_status_dec
  import xcas_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  bus_stat_t stat,
  output logic      ack_hit,
  output logic      xack_n
);
  assign ack_hit = is_int_ack(stat);

  always_ff @(posedge clk) begin
    if (!rst_n) xack_n <= 1'b1;
    else        xack_n <= !ack_hit;
  end

  // R2: a cycle that is not an acknowledge never produces the strobe
  a_r2_no_false_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (stat.refresh_n == 1'b0) |=> xack_n);
endmodule

// File: rtl/xcas_code_latch.sv
module xcas_code_latch #(
  parameter int CODE_W  = 3,
  parameter int TIMEOUT = 64,
  localparam int TW     = $clog2(TIMEOUT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cas_en,
  input  logic              ack_hit,
  input  logic [CODE_W-1:0] addr_cas,
  output logic              phase,
  output logic [CODE_W-1:0] code_q,
  output logic [CODE_W-1:0] cur_code
);
  logic [TW-1:0] gap_cnt;
  logic          gap_last;

  assign gap_last = (gap_cnt == TW'(TIMEOUT - 1));
  assign cur_code = phase ? code_q : addr_cas;

  always_ff @(posedge clk) begin
    if (!rst_n || !cas_en) begin
      phase   <= 1'b0;
      code_q  <= '0;
      gap_cnt <= '0;
    end else if (ack_hit) begin
      gap_cnt <= '0;
      if (!phase) begin
        code_q <= addr_cas;
        phase  <= 1'b1;
      end else begin
        phase  <= 1'b0;
      end
    end else if (phase) begin
      if (gap_last) begin
        phase   <= 1'b0;
        code_q  <= '0;
        gap_cnt <= '0;
      end else begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  // R3: first acknowledge captures the pins
  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_en && ack_hit && !phase) |=> (phase && code_q == $past(addr_cas)));
  // R4: second acknowledge keeps the code and closes the pair
  a_r4_hold_second: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_en && ack_hit && phase) |=> (!phase && $stable(code_q)));
  // R9: idle gap short of the limit leaves the code alone
  a_r9_gap_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_en && !ack_hit && phase && !gap_last) |=> (phase && $stable(code_q)));
  // R8: gap counter never runs past the limit
  a_r8_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
    gap_cnt < TW'(TIMEOUT));
endmodule

// File: rtl/xcas_slave_match.sv
module xcas_slave_match #(
  parameter int CODE_W   = 3,
  parameter int N_SLAVES = 4,
  parameter logic [N_SLAVES*CODE_W-1:0] SLAVE_IDS = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cas_en,
  input  logic                ack_hit,
  input  logic [CODE_W-1:0]   cur_code,
  output logic [N_SLAVES-1:0] sel
);
  for (genvar i = 0; i < N_SLAVES; i++) begin : g_slot
    localparam logic [CODE_W-1:0] MY_ID = SLAVE_IDS[i*CODE_W +: CODE_W];
    always_ff @(posedge clk) begin
      if (!rst_n) sel[i] <= 1'b0;
      else        sel[i] <= cas_en && ack_hit && (cur_code == MY_ID);
    end
  end

  // R7: never two slaves at once
  a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  // R6: no select without an acknowledge on the previous edge
  a_r6_only_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_hit |=> (sel == '0));
endmodule

// File: rtl/xcas_ack_glue.sv
module xcas_ack_glue
  import xcas_pkg::*;
#(
  parameter int CODE_W   = 3,
  parameter int N_SLAVES = 4,
  parameter int TIMEOUT  = 64,
  parameter logic [N_SLAVES*CODE_W-1:0] SLAVE_IDS = {3'd7, 3'd4, 3'd2, 3'd1}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cas_en,
  input  logic [CODE_W-1:0]   addr_cas,
  input  logic                ads_n,
  input  logic                mio_n,
  input  logic                dc_n,
  input  logic                wr_n,
  input  logic                refresh_n,
  output logic                xack_n,
  output logic                ack_phase,
  output logic [CODE_W-1:0]   cas_code,
  output logic [N_SLAVES-1:0] slave_sel
);
  bus_stat_t         stat;
  logic              ack_hit;
  logic [CODE_W-1:0] cur_code;

  assign stat = '{ads_n: ads_n, mio_n: mio_n, dc_n: dc_n, wr_n: wr_n, refresh_n: refresh_n};

  xcas_status_dec u_dec (
    .clk(clk), .rst_n(rst_n), .stat(stat), .ack_hit(ack_hit), .xack_n(xack_n)
  );

  xcas_code_latch #(.CODE_W(CODE_W), .TIMEOUT(TIMEOUT)) u_latch (
    .clk(clk), .rst_n(rst_n), .cas_en(cas_en), .ack_hit(ack_hit),
    .addr_cas(addr_cas), .phase(ack_phase), .code_q(cas_code), .cur_code(cur_code)
  );

  xcas_slave_match #(.CODE_W(CODE_W), .N_SLAVES(N_SLAVES), .SLAVE_IDS(SLAVE_IDS)) u_match (
    .clk(clk), .rst_n(rst_n), .cas_en(cas_en), .ack_hit(ack_hit),
    .cur_code(cur_code), .sel(slave_sel)
  );

  // R5: cleared enable drops all state and selects
  a_r5_disabled_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_en |=> (!ack_phase && cas_code == '0 && slave_sel == '0));
  // R2: strobe follows the sampled acknowledge pattern
  a_r2_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_n && !mio_n && !dc_n && !wr_n && refresh_n) |=> !xack_n);
endmodule

// File: tb/tb_xcas_ack_glue.sv
module tb_xcas_ack_glue;
  localparam int TO = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cas_en = 1'b0;
  logic [2:0] addr_cas = 3'b000;
  logic       ads_n = 1'b1, mio_n = 1'b1, dc_n = 1'b1, wr_n = 1'b1, refresh_n = 1'b1;
  logic       xack_n, ack_phase;
  logic [2:0] cas_code;
  logic [3:0] slave_sel;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  xcas_ack_glue #(.CODE_W(3), .N_SLAVES(4), .TIMEOUT(TO),
                  .SLAVE_IDS({3'd7, 3'd4, 3'd2, 3'd1})) dut (
    .clk(clk), .rst_n(rst_n), .cas_en(cas_en), .addr_cas(addr_cas),
    .ads_n(ads_n), .mio_n(mio_n), .dc_n(dc_n), .wr_n(wr_n), .refresh_n(refresh_n),
    .xack_n(xack_n), .ack_phase(ack_phase), .cas_code(cas_code), .slave_sel(slave_sel)
  );

  // {ads_n, mio_n, dc_n, wr_n, refresh_n, expected xack_n}
  localparam logic [5:0] VEC [8] = '{
    6'b00001_0, 6'b10001_1, 6'b01001_1, 6'b00101_1,
    6'b00011_1, 6'b00000_1, 6'b11111_1, 6'b00001_0
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [4:0] st, input logic [2:0] a);
    {ads_n, mio_n, dc_n, wr_n, refresh_n} = st;
    addr_cas = a;
    @(posedge clk); #1;
  endtask

  localparam logic [4:0] ACK  = 5'b00001;
  localparam logic [4:0] IDLE = 5'b11111;
  localparam logic [4:0] MEMR = 5'b01101;

  initial begin
    #1;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 xack_n", xack_n, 1); chk("R1 phase", ack_phase, 0);
    chk("R1 code", cas_code, 0); chk("R1 sel", slave_sel, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      cyc(VEC[i][5:1], 3'd2);
      chk("R2 strobe", xack_n, VEC[i][0]);
      chk("R5 no capture", ack_phase, 0);
      chk("R5 no sel", slave_sel, 0);
    end

    cas_en = 1'b1;
    cyc(ACK, 3'd2);
    chk("R2 strobe first", xack_n, 0);
    chk("R3 phase", ack_phase, 1); chk("R3 code", cas_code, 2);
    chk("R6 sel first", slave_sel, 4'b0010);
    cyc(IDLE, 3'd7);
    chk("R9 code idle", cas_code, 2); chk("R6 sel idle", slave_sel, 0);
    chk("R2 idle strobe", xack_n, 1);
    cyc(MEMR, 3'd5);
    cyc(IDLE, 3'd7);
    chk("R9 code gap", cas_code, 2); chk("R9 phase gap", ack_phase, 1);
    cyc(ACK, 3'd7);
    chk("R4 code", cas_code, 2); chk("R4 phase", ack_phase, 0);
    chk("R6 sel second", slave_sel, 4'b0010);
    chk("R7 one sel", $countones(slave_sel), 1);

    cyc(ACK, 3'd5);
    chk("R6 no match", slave_sel, 0); chk("R3 code5", cas_code, 5);
    for (int k = 0; k < TO - 1; k++) cyc(IDLE, 3'(k));
    chk("R8 before limit phase", ack_phase, 1); chk("R8 before limit code", cas_code, 5);
    cyc(IDLE, 3'd7);
    chk("R8 at limit phase", ack_phase, 0); chk("R8 at limit code", cas_code, 0);

    cyc(ACK, 3'd4);
    chk("R6 sel slot2", slave_sel, 4'b0100);
    cas_en = 1'b0;
    cyc(IDLE, 3'd7);
    chk("R5 phase", ack_phase, 0); chk("R5 code", cas_code, 0);
    cyc(ACK, 3'd4);
    chk("R5 strobe", xack_n, 0); chk("R5 sel", slave_sel, 0);
    chk("R5 phase ack", ack_phase, 0); chk("R5 code ack", cas_code, 0);

    cas_en = 1'b1;
    cyc(ACK, 3'd1);
    chk("R6 sel slot0", slave_sel, 4'b0001);
    rst_n = 1'b0;
    cyc(ACK, 3'd7);
    chk("R1 mid phase", ack_phase, 0); chk("R1 mid code", cas_code, 0);
    chk("R1 mid sel", slave_sel, 0); chk("R1 mid xack", xack_n, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule